// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block remembers interrupt sources whose delivery the downstream interrupt presenter turned away, and replays them when told to. Each rejection arrives as a global interrupt number. The block subtracts a programmable base offset from it to get a local source number, then records that source as one bit in a store of `NUM_WORDS` words of `WORD_BITS` bits each. A summary register holds one bit per word, and that bit is set whenever its word may hold a recorded source.

When a resend command arrives, a walker visits the words whose summary bit is set, in ascending word order. It clears each word's summary bit as it enters the word. Inside the word it hands out one forced trigger for every set bit, in ascending bit order, and clears each bit as the consumer accepts its trigger. Triggers leave on a valid/ready handshake, one per cycle while the consumer is ready. A single-cycle done pulse marks the end of the walk. A forced trigger means the stored pending/queued state of the source is bypassed; the logic that performs that bypass lies outside this block.

Top module: `rir_resend_top`

## Requirements
- R1: The local source number is `rej_num - base_offset`. It is stored at word `src >> 6`, bit `src & 63`. `trig_src` carries that same local number as an 11-bit binary value.
- R2: A legal reject records its source. Rejecting the same source several times before a resend replays it exactly once.
- R3: A reject is ignored and leaves no trace in any later replay when `rej_num < base_offset`, or when the local number is 2048 or more.
- R4: A resend command while nothing is recorded emits no trigger. `walk_done` pulses on the cycle right after the command is sampled.
- R5: A walk replays the recorded sources in ascending order: words 0 to 31 first, and bits 0 to 63 within each word.
- R6: Every replayed source is cleared, so a second resend with no new rejects emits no trigger.
- R7: While `trig_valid` is high and `trig_ready` is low, `trig_valid` stays high and `trig_src` stays unchanged. With `trig_ready` held high, sources in the same word leave on consecutive cycles.
- R8: `walk_busy` is high from the cycle after a resend command until the walk ends. `walk_done` is a single-cycle pulse during which `trig_valid` is low.
- R9: A reject that arrives during a walk, for a word the walk has already left, is not replayed in that walk. It is replayed by the next resend.
- R10: Synchronous reset clears every recorded source and the summary, and returns the outputs to idle: `trig_valid`, `walk_busy` and `walk_done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | 16 | Global interrupt number of the rejected source |
| base_offset | input | 16 | Global number of local source 0 |
| resend_req | input | 1 | Start a replay walk (ignored while busy) |
| trig_valid | output | 1 | Forced trigger available |
| trig_src | output | 11 | Local source number of the forced trigger |
| trig_ready | input | 1 | Consumer accepts the trigger |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench places rejects at the edges of words (sources 0, 63, 64 and 2047) and sends duplicates. A design with a wrong word/bit split or a wrong scan order would replay sources misplaced or out of order, and a duplicate replay would show up as an extra trigger. Rejects below the base and at the 2048 limit are sent to catch a missing range check. A design without that check would replay a wrapped-around source. Under alternating backpressure, a walker that advanced without a handshake would skip or repeat sources. A reject injected into a word the walk has already passed catches a walker that rescans from the lowest summary bit: that design would replay the source too early.

// File: rtl/rir_pkg.sv
package rir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_LOAD,
    ST_EMIT
  } walk_state_e;
endpackage

// File: rtl/rir_lsb_find.sv
module rir_lsb_find #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rir_bitmap_store.sv
module rir_bitmap_store #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  parameter int WI_W      = $clog2(NUM_WORDS),
  parameter int BI_W      = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [WI_W-1:0]      set_word,
  input  logic [BI_W-1:0]      set_bit,
  input  logic                 clr_en,
  input  logic [WI_W-1:0]      clr_word,
  input  logic [BI_W-1:0]      clr_bit,
  input  logic [WI_W-1:0]      rd_idx,
  output logic [WORD_BITS-1:0] rd_data
);
  logic [WORD_BITS-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) words[w] <= '0;
    end else begin
      if (clr_en) words[clr_word][clr_bit] <= 1'b0;
      // set comes last so a new reject wins over a same-cycle clear
      if (set_en) words[set_word][set_bit] <= 1'b1;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/rir_summary.sv
module rir_summary #(
  parameter int NUM_WORDS = 32,
  parameter int WI_W      = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [WI_W-1:0]      set_idx,
  input  logic                 clr_en,
  input  logic [WI_W-1:0]      clr_idx,
  output logic [NUM_WORDS-1:0] summary
);
  always_ff @(posedge clk) begin
    if (rst) begin
      summary <= '0;
    end else begin
      if (clr_en) summary[clr_idx] <= 1'b0;
      if (set_en) summary[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/rir_walker.sv
module rir_walker
  import rir_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  parameter int WI_W      = $clog2(NUM_WORDS),
  parameter int BI_W      = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 resend_req,
  input  logic [NUM_WORDS-1:0] summary,
  output logic                 sum_clr_en,
  output logic [WI_W-1:0]      sum_clr_idx,
  output logic [WI_W-1:0]      rd_idx,
  input  logic [WORD_BITS-1:0] rd_data,
  output logic                 bit_clr_en,
  output logic [WI_W-1:0]      bit_clr_word,
  output logic [BI_W-1:0]      bit_clr_bit,
  output logic                 trig_valid,
  output logic [WI_W+BI_W-1:0] trig_src,
  input  logic                 trig_ready,
  output logic                 walk_busy,
  output logic                 walk_done
);
  walk_state_e          state;
  logic [WI_W:0]        next_word;
  logic [WI_W-1:0]      cur_word;
  logic [BI_W-1:0]      cur_bit;
  logic [NUM_WORDS-1:0] sum_masked;
  logic [WORD_BITS-1:0] find_vec;
  logic                 sum_found, bit_found;
  logic [WI_W-1:0]      sum_idx;
  logic [BI_W-1:0]      bit_idx;

  // only words at or beyond the walk position are candidates
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++)
      sum_masked[i] = summary[i] && (i >= int'(next_word));
  end

  // in EMIT, look past the bit currently being offered
  assign find_vec = (state == ST_EMIT) ?
                    (rd_data & ~(WORD_BITS'(1) << cur_bit)) : rd_data;

  rir_lsb_find #(.W(NUM_WORDS), .IW(WI_W)) sum_find_i (
    .vec(sum_masked), .found(sum_found), .idx(sum_idx));

  rir_lsb_find #(.W(WORD_BITS), .IW(BI_W)) bit_find_i (
    .vec(find_vec), .found(bit_found), .idx(bit_idx));

  assign sum_clr_en   = (state == ST_SEEK) && sum_found;
  assign sum_clr_idx  = sum_idx;
  assign rd_idx       = cur_word;
  assign bit_clr_en   = (state == ST_EMIT) && trig_ready;
  assign bit_clr_word = cur_word;
  assign bit_clr_bit  = cur_bit;
  assign trig_src     = {cur_word, cur_bit};
  assign walk_busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      next_word  <= '0;
      cur_word   <= '0;
      cur_bit    <= '0;
      trig_valid <= 1'b0;
      walk_done  <= 1'b0;
    end else begin
      walk_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (resend_req) begin
            if (summary == '0) begin
              walk_done <= 1'b1;
            end else begin
              next_word <= '0;
              state     <= ST_SEEK;
            end
          end
        end
        ST_SEEK: begin
          if (sum_found) begin
            cur_word  <= sum_idx;
            next_word <= (WI_W+1)'(sum_idx) + 1'b1;
            state     <= ST_LOAD;
          end else begin
            walk_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          if (bit_found) begin
            cur_bit    <= bit_idx;
            trig_valid <= 1'b1;
            state      <= ST_EMIT;
          end else begin
            state <= ST_SEEK;
          end
        end
        default: begin
          if (trig_ready) begin
            if (bit_found) begin
              cur_bit <= bit_idx;
            end else begin
              trig_valid <= 1'b0;
              state      <= ST_SEEK;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rir_resend_top.sv
module rir_resend_top #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64,
  parameter int GNUM_W    = 16,
  parameter int SRC_W     = $clog2(NUM_WORDS * WORD_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rej_valid,
  input  logic [GNUM_W-1:0] rej_num,
  input  logic [GNUM_W-1:0] base_offset,
  input  logic              resend_req,
  output logic              trig_valid,
  output logic [SRC_W-1:0]  trig_src,
  input  logic              trig_ready,
  output logic              walk_busy,
  output logic              walk_done
);
  localparam int NUM_SRC = NUM_WORDS * WORD_BITS;
  localparam int WI_W    = $clog2(NUM_WORDS);
  localparam int BI_W    = $clog2(WORD_BITS);

  logic [GNUM_W-1:0]    local_num;
  logic                 rej_ok;
  logic [WI_W-1:0]      set_word;
  logic [BI_W-1:0]      set_bit;
  logic [NUM_WORDS-1:0] summary;
  logic                 sum_clr_en, bit_clr_en;
  logic [WI_W-1:0]      sum_clr_idx, rd_idx, bit_clr_word;
  logic [BI_W-1:0]      bit_clr_bit;
  logic [WORD_BITS-1:0] rd_data;

  assign local_num = rej_num - base_offset;
  assign rej_ok    = rej_valid && (rej_num >= base_offset) &&
                     (32'(local_num) < NUM_SRC);
  assign set_word  = WI_W'(32'(local_num) >> BI_W);
  assign set_bit   = BI_W'(local_num);

  rir_bitmap_store #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) store_i (
    .clk(clk), .rst(rst),
    .set_en(rej_ok), .set_word(set_word), .set_bit(set_bit),
    .clr_en(bit_clr_en), .clr_word(bit_clr_word), .clr_bit(bit_clr_bit),
    .rd_idx(rd_idx), .rd_data(rd_data));

  rir_summary #(.NUM_WORDS(NUM_WORDS)) summary_i (
    .clk(clk), .rst(rst),
    .set_en(rej_ok), .set_idx(set_word),
    .clr_en(sum_clr_en), .clr_idx(sum_clr_idx),
    .summary(summary));

  rir_walker #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) walker_i (
    .clk(clk), .rst(rst), .resend_req(resend_req), .summary(summary),
    .sum_clr_en(sum_clr_en), .sum_clr_idx(sum_clr_idx),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .bit_clr_en(bit_clr_en), .bit_clr_word(bit_clr_word), .bit_clr_bit(bit_clr_bit),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .walk_busy(walk_busy), .walk_done(walk_done));
endmodule

// File: rtl/rir_resend_chk.sv
module rir_resend_chk #(
  parameter int SRC_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_valid,
  input logic [SRC_W-1:0] trig_src,
  input logic             trig_ready,
  input logic             walk_busy,
  input logic             walk_done
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_valid && !trig_ready) |=> (trig_valid && $stable(trig_src)));

  // R7
  valid_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    trig_valid |-> walk_busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> (!trig_valid && !walk_busy));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!trig_valid && !walk_busy && !walk_done));
endmodule

bind rir_resend_top rir_resend_chk #(.SRC_W(SRC_W)) chk_i (
  .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_src(trig_src),
  .trig_ready(trig_ready), .walk_busy(walk_busy), .walk_done(walk_done));

// File: tb/rir_resend_top_tb_top.sv
module rir_resend_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 2048;
  localparam logic [15:0] BASE = 16'd100;

  // stimulus: global numbers; expected: whether each one is legal
  localparam int NTAB = 9;
  localparam logic [15:0] REJ_TAB [NTAB] = '{
    16'd2147, 16'd163, 16'd100, 16'd99, 16'd164,
    16'd700,  16'd163, 16'd2148, 16'd1000 };
  localparam logic REJ_OK [NTAB] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                     1'b1, 1'b1, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rej_valid = 1'b0;
  logic [15:0] rej_num = '0;
  logic [15:0] base_offset = BASE;
  logic        resend_req = 1'b0;
  logic        trig_ready = 1'b0;
  logic        trig_valid, walk_busy, walk_done;
  logic [10:0] trig_src;

  int n_tests = 0;
  int n_fail  = 0;

  logic model [NSRC];
  int   cap [64];
  int   ncap;
  int   done_iter;
  int   stall_err;
  int   busy_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  rir_resend_top dut_i (
    .clk(clk), .rst(rst), .rej_valid(rej_valid), .rej_num(rej_num),
    .base_offset(base_offset), .resend_req(resend_req),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .walk_busy(walk_busy), .walk_done(walk_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NSRC; i++) model[i] = 1'b0;
  endtask

  task automatic reject(input logic [15:0] g, input logic legal);
    @(negedge clk);
    rej_valid = 1'b1;
    rej_num   = g;
    @(negedge clk);
    rej_valid = 1'b0;
    if (legal) model[int'(g) - int'(BASE)] = 1'b1;
  endtask

  // mode 0: always ready; mode 1: ready on alternate cycles
  task automatic run_walk(input int mode, input int inj_at, input logic [15:0] inj_num);
    bit prev_stall = 0;
    bit injected = 0;
    logic [10:0] prev_src = '0;
    ncap = 0; done_iter = -1; stall_err = 0; busy_err = 0;
    @(negedge clk);
    resend_req = 1'b1;
    for (int it = 1; it < 6000; it++) begin
      @(negedge clk);
      resend_req = 1'b0;
      rej_valid  = 1'b0;
      trig_ready = (mode == 0) ? 1'b1 : logic'(it % 2);
      if (trig_valid && prev_stall && trig_src != prev_src) stall_err++;
      if (walk_done) begin
        done_iter = it;
        break;
      end
      if (!walk_busy) busy_err++;
      if (trig_valid && trig_ready && ncap < 64) begin
        cap[ncap] = int'(trig_src);
        ncap++;
      end
      if (!injected && inj_at >= 0 && ncap == inj_at) begin
        rej_valid = 1'b1;
        rej_num   = inj_num;
        injected  = 1;
      end
      prev_stall = trig_valid && !trig_ready;
      prev_src   = trig_src;
    end
    @(negedge clk);
    trig_ready = 1'b0;
    rej_valid  = 1'b0;
    check(done_iter > 0, "R8 walk finished", done_iter, 1);
    check(walk_done == 1'b0, "R8 done single cycle", int'(walk_done), 0);
  endtask

  // compares the captured replay against the model in ascending order, then clears the model
  task automatic compare_model(input string req);
    int k = 0;
    bit order_ok = 1;
    for (int i = 0; i < NSRC; i++) begin
      if (model[i]) begin
        if (k >= ncap || cap[k] != i) begin
          if (order_ok)
            $display("FAIL %s source slot %0d actual=%0d expected=%0d",
                     req, k, (k < ncap) ? cap[k] : -1, i);
          order_ok = 0;
        end
        k++;
      end
    end
    n_tests++;
    if (!order_ok) n_fail++;
    check(ncap == k, {req, " trigger count"}, ncap, k);
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    n_fail++;
    n_tests++;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check(trig_valid == 1'b0, "R10 trig_valid after reset", int'(trig_valid), 0);
    check(walk_busy == 1'b0, "R10 walk_busy after reset", int'(walk_busy), 0);
    check(walk_done == 1'b0, "R10 walk_done after reset", int'(walk_done), 0);

    // R4: empty resend
    run_walk(0, -1, '0);
    check(ncap == 0, "R4 no trigger when empty", ncap, 0);
    check(done_iter == 1, "R4 done latency", done_iter, 1);

    // vector table: R1 mapping, R2 duplicates, R3 illegal entries, R5 order
    for (int v = 0; v < NTAB; v++) reject(REJ_TAB[v], REJ_OK[v]);
    run_walk(0, -1, '0);
    compare_model("R1 R2 R3 R5 table");
    check(ncap == 6, "R2 duplicate replayed once", ncap, 6);
    check(busy_err == 0, "R8 busy during walk", busy_err, 0);

    // R6: nothing left after a walk
    run_walk(0, -1, '0);
    check(ncap == 0, "R6 bitmap cleared by walk", ncap, 0);

    // R3: only illegal rejects
    reject(16'd99, 1'b0);
    reject(16'd2148, 1'b0);
    reject(16'd0, 1'b0);
    run_walk(0, -1, '0);
    check(ncap == 0, "R3 illegal rejects ignored", ncap, 0);

    // R7: backpressure, same-word neighbours
    reject(16'd103, 1'b1);
    reject(16'd104, 1'b1);
    reject(16'd105, 1'b1);
    reject(16'd230, 1'b1);
    run_walk(1, -1, '0);
    compare_model("R7 backpressure");
    check(stall_err == 0, "R7 source stable under stall", stall_err, 0);

    // R9: reject into a passed word during the walk
    reject(16'd105, 1'b1);
    reject(16'd300, 1'b1);
    reject(16'd1600, 1'b1);
    run_walk(0, 2, 16'd110);
    compare_model("R9 first walk");
    model[10] = 1'b1;
    run_walk(0, -1, '0);
    compare_model("R9 second walk");

    // R10: reset drops recorded sources
    reject(16'd150, 1'b1);
    reject(16'd1900, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    run_walk(0, -1, '0);
    check(ncap == 0, "R10 reset clears bitmap", ncap, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule